// File: doc/BRIEF.md
# Shared-Bus Interrupt Master Sequencer

This block is the bus-master half of a maintenance panel's access logic for a shared system bus. When the panel raises an interrupt request, the block asks the bus controller for the bus. If another function already holds the shared select line, it first waits for that line to be released. It then waits for the controller to pull select low and send a precedence pulse. Once it has the grant, it acknowledges and enables its address and data drivers. The panel's own address goes onto the address lines, and the data lines carry an all-zero word as the interrupt payload.

After the precedence pulse has returned low, the block issues the bus strobe and waits for the slave's done reply. If done never arrives, the bus controller times the transfer out and sends a quit. Done and quit have the same effect: acknowledge, strobe and both output enables are dropped together and the sequencer goes back to idle. A request that arrives while a transfer is in progress is held and served next. A synchronous active-high reset clears the sequencer and any held request.

Top module: `bus_irq_master`

## Requirements
- R1: While reset is high and on the first cycle after it, req_n_o, ack_n_o and strb_n_o are 1, addr_oe_o, data_oe_o and write_o are 0, and addr_o is all zeros.
- R2: An interrupt request seen in idle while sel_bus_n_i is 1 drives req_n_o low from the next cycle. req_n_o stays low until the grant is taken.
- R3: An interrupt request seen in idle while sel_bus_n_i is 0 keeps req_n_o high. req_n_o goes low one cycle after sel_bus_n_i is seen high.
- R4: While requesting, the block takes the grant only in a cycle where prec_i is 1 and sel_bus_n_i is 0. ack_n_o goes low on the next cycle, and req_n_o goes high on that same cycle. A precedence pulse while sel_bus_n_i is 1 is ignored.
- R5: While ack_n_o is low, addr_oe_o and data_oe_o are 1 and addr_o equals PANEL_ADDR. Outside that window, addr_o is zero. strb_n_o stays high as long as prec_i stays 1.
- R6: strb_n_o goes low one cycle after prec_i is seen 0 during the acknowledge phase. ack_n_o and both enables are held while the strobe is low.
- R7: write_o is 1 exactly when addr_oe_o is 1 and read_mode_i is 0.
- R8: done_n_i seen low while strobing raises strb_n_o and ack_n_o and clears both enables on the next cycle, all in the same cycle, and the block returns to idle.
- R9: quit_n_i seen low while strobing causes the same release as R8.
- R10: done_n_i or quit_n_i pulsed low outside the strobe phase has no effect on the outputs.
- R11: An interrupt request that arrives during a transfer is held and starts a new bus request after the block returns to idle.
- R12: Reset during a transfer returns all outputs to the R1 values and discards a held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| irq_req_i | input | 1 | Interrupt request from the panel, one cycle high |
| read_mode_i | input | 1 | Panel is in a read-mode state |
| sel_bus_n_i | input | 1 | Shared select line, low while some function holds it |
| prec_i | input | 1 | Precedence pulse from the bus controller |
| done_n_i | input | 1 | Slave done reply, active low |
| quit_n_i | input | 1 | Controller timeout quit, active low |
| req_n_o | output | 1 | Select request to the bus controller, active low |
| ack_n_o | output | 1 | Bus acknowledge, active low |
| strb_n_o | output | 1 | Bus strobe, active low |
| addr_oe_o | output | 1 | Address-out enable |
| data_oe_o | output | 1 | Data-out enable (zero word) |
| write_o | output | 1 | Write direction with address-out |
| addr_o | output | ADDR_W | Panel address while address-out is enabled |

## Verification
The sequence is run along several paths. One starts with the shared select free; another starts with it held by another function, which tells the deferral path apart from the direct claim. In the requesting phase, a precedence pulse is given while select is still high, to show that the grant needs both signals. Stray done and quit pulses are also sent in that phase, to show that the response lines only act while strobing. One transfer ends with done and another runs past the 2 µs window of a clocked counter until the controller quits, which separates the two exits. Read mode is toggled between runs to tell apart the two write-direction values. A request raised mid-transfer and a reset given mid-acknowledge show that a held request is kept in the first case and discarded in the second.

// File: rtl/irq_bus_pkg.sv
package irq_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEFER = 3'd1,
        ST_CLAIM = 3'd2,
        ST_ACK   = 3'd3,
        ST_STRB  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic req;
        logic ack;
        logic strb;
        logic oe;
    } bus_drv_t;

    function automatic bus_drv_t drive_of(seq_state_t s);
        bus_drv_t d;
        d.req  = (s == ST_CLAIM);
        d.ack  = (s == ST_ACK) || (s == ST_STRB);
        d.strb = (s == ST_STRB);
        d.oe   = (s == ST_ACK) || (s == ST_STRB);
        return d;
    endfunction

endpackage

// File: rtl/irq_hold.sv
module irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic irq_req_i,
    input  logic idle_i,
    input  logic start_i,
    output logic want_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b0;
        end else if (irq_req_i && !idle_i) begin
            pend_q <= 1'b1;
        end
    end

    assign want_o = irq_req_i || pend_q;
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
    import irq_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       want_i,
    input  logic       sel_bus_n_i,
    input  logic       prec_i,
    input  logic       done_n_i,
    input  logic       quit_n_i,
    output logic       idle_o,
    output logic       start_o,
    output bus_drv_t   drv_o
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (want_i) state_d = sel_bus_n_i ? ST_CLAIM : ST_DEFER;
            ST_DEFER: if (sel_bus_n_i) state_d = ST_CLAIM;
            ST_CLAIM: if (prec_i && !sel_bus_n_i) state_d = ST_ACK;
            ST_ACK:   if (!prec_i) state_d = ST_STRB;
            ST_STRB:  if (!done_n_i || !quit_n_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign idle_o  = (state_q == ST_IDLE);
    assign start_o = idle_o && want_i;
    assign drv_o   = drive_of(state_q);
endmodule

// File: rtl/bus_out_drive.sv
module bus_out_drive
    import irq_bus_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PANEL_ADDR = 16'h00F0
) (
    input  bus_drv_t          drv_i,
    input  logic              read_mode_i,
    output logic              req_n_o,
    output logic              ack_n_o,
    output logic              strb_n_o,
    output logic              addr_oe_o,
    output logic              data_oe_o,
    output logic              write_o,
    output logic [ADDR_W-1:0] addr_o
);
    assign req_n_o   = !drv_i.req;
    assign ack_n_o   = !drv_i.ack;
    assign strb_n_o  = !drv_i.strb;
    assign addr_oe_o = drv_i.oe;
    assign data_oe_o = drv_i.oe;
    assign write_o   = drv_i.oe && !read_mode_i;
    assign addr_o    = drv_i.oe ? PANEL_ADDR : '0;
endmodule

// File: rtl/bus_irq_master.sv
module bus_irq_master
    import irq_bus_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PANEL_ADDR = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req_i,
    input  logic              read_mode_i,
    input  logic              sel_bus_n_i,
    input  logic              prec_i,
    input  logic              done_n_i,
    input  logic              quit_n_i,
    output logic              req_n_o,
    output logic              ack_n_o,
    output logic              strb_n_o,
    output logic              addr_oe_o,
    output logic              data_oe_o,
    output logic              write_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic     want, idle, start;
    bus_drv_t drv;

    irq_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .irq_req_i (irq_req_i),
        .idle_i    (idle),
        .start_i   (start),
        .want_o    (want)
    );

    bus_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .want_i      (want),
        .sel_bus_n_i (sel_bus_n_i),
        .prec_i      (prec_i),
        .done_n_i    (done_n_i),
        .quit_n_i    (quit_n_i),
        .idle_o      (idle),
        .start_o     (start),
        .drv_o       (drv)
    );

    bus_out_drive #(.ADDR_W(ADDR_W), .PANEL_ADDR(PANEL_ADDR)) u_drive (
        .drv_i       (drv),
        .read_mode_i (read_mode_i),
        .req_n_o     (req_n_o),
        .ack_n_o     (ack_n_o),
        .strb_n_o    (strb_n_o),
        .addr_oe_o   (addr_oe_o),
        .data_oe_o   (data_oe_o),
        .write_o     (write_o),
        .addr_o      (addr_o)
    );
endmodule

// File: rtl/bus_irq_master_chk.sv
module bus_irq_master_chk #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PANEL_ADDR = 16'h00F0
) (
    input logic              clk,
    input logic              rst,
    input logic              read_mode_i,
    input logic              sel_bus_n_i,
    input logic              prec_i,
    input logic              done_n_i,
    input logic              quit_n_i,
    input logic              req_n_o,
    input logic              ack_n_o,
    input logic              strb_n_o,
    input logic              addr_oe_o,
    input logic              data_oe_o,
    input logic              write_o,
    input logic [ADDR_W-1:0] addr_o
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (req_n_o && ack_n_o && strb_n_o && !addr_oe_o && !data_oe_o));

    a_r4_grant_qualified: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n_o) |-> ($past(prec_i) && !$past(sel_bus_n_i) && !$past(req_n_o)));

    a_r4_req_ack_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!req_n_o, !ack_n_o}));

    a_r5_enables_with_ack: assert property (@(posedge clk) disable iff (rst)
        !ack_n_o |-> (addr_oe_o && data_oe_o && addr_o == PANEL_ADDR));

    a_r6_strobe_after_prec_low: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_n_o) |-> (!$past(prec_i) && !$past(ack_n_o)));

    a_r6_strobe_needs_ack: assert property (@(posedge clk) disable iff (rst)
        !strb_n_o |-> !ack_n_o);

    a_r7_write_dir: assert property (@(posedge clk) disable iff (rst)
        write_o |-> (addr_oe_o && !read_mode_i));

    a_r8_done_release: assert property (@(posedge clk) disable iff (rst)
        (!strb_n_o && !done_n_i) |=> (strb_n_o && ack_n_o && !addr_oe_o && !data_oe_o));

    a_r9_quit_release: assert property (@(posedge clk) disable iff (rst)
        (!strb_n_o && !quit_n_i) |=> (strb_n_o && ack_n_o && !addr_oe_o && !data_oe_o));
endmodule

bind bus_irq_master bus_irq_master_chk #(.ADDR_W(ADDR_W), .PANEL_ADDR(PANEL_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .read_mode_i (read_mode_i),
    .sel_bus_n_i (sel_bus_n_i),
    .prec_i      (prec_i),
    .done_n_i    (done_n_i),
    .quit_n_i    (quit_n_i),
    .req_n_o     (req_n_o),
    .ack_n_o     (ack_n_o),
    .strb_n_o    (strb_n_o),
    .addr_oe_o   (addr_oe_o),
    .data_oe_o   (data_oe_o),
    .write_o     (write_o),
    .addr_o      (addr_o)
);

// File: tb/test_bus_irq_master.sv
module test_bus_irq_master;
    localparam int          ADDR_W   = 16;
    localparam logic [15:0] PANEL    = 16'h00F0;
    localparam int          CLK_MHZ  = 100;
    localparam int          QUIT_CYC = 2 * CLK_MHZ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0, rd = 1'b0, sel_n = 1'b1, prec = 1'b0, done_n = 1'b1, quit_n = 1'b1;
    logic req_n, ack_n, strb_n, aoe, doe, wr;
    logic [ADDR_W-1:0] addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_irq_master #(.ADDR_W(ADDR_W), .PANEL_ADDR(PANEL)) i_bus_irq_master (
        .clk(clk), .rst(rst), .irq_req_i(irq), .read_mode_i(rd),
        .sel_bus_n_i(sel_n), .prec_i(prec), .done_n_i(done_n), .quit_n_i(quit_n),
        .req_n_o(req_n), .ack_n_o(ack_n), .strb_n_o(strb_n),
        .addr_oe_o(aoe), .data_oe_o(doe), .write_o(wr), .addr_o(addr)
    );

    // Behavioural reference: phase 0 idle, 1 deferring, 2 requesting, 3 acknowledged, 4 strobing
    int  m_phase = 0;
    bit  m_held  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0;
            m_held  <= 0;
        end else begin
            if (m_phase == 0) begin
                if (irq || m_held) begin
                    m_phase <= sel_n ? 2 : 1;
                    m_held  <= 0;
                end
            end else begin
                if (irq) m_held <= 1;
                if (m_phase == 1 && sel_n) m_phase <= 2;
                if (m_phase == 2 && prec && !sel_n) m_phase <= 3;
                if (m_phase == 3 && !prec) m_phase <= 4;
                if (m_phase == 4 && (!done_n || !quit_n)) m_phase <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            logic e_on;
            e_on = (m_phase >= 3);
            chk(req_n === !(m_phase == 2), "R2 req_n vs model", req_n, !(m_phase == 2));
            chk(ack_n === !e_on, "R4 ack_n vs model", ack_n, !e_on);
            chk(strb_n === !(m_phase == 4), "R6 strb_n vs model", strb_n, !(m_phase == 4));
            chk(aoe === e_on && doe === e_on && addr === (e_on ? PANEL : 16'h0),
                "R5 enables/addr vs model", {aoe, doe, addr}, {e_on, e_on, (e_on ? PANEL : 16'h0)});
            chk(wr === (e_on && !rd), "R7 write vs model", wr, (e_on && !rd));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_released(input string tag);
        chk(req_n && ack_n && strb_n && !aoe && !doe && !wr && addr == '0, tag,
            {req_n, ack_n, strb_n, aoe, doe, wr}, 6'b111000);
    endtask

    task automatic xfer(input bit busy, input int dly, input bit use_quit,
                        input bit rd_v, input bit irq_mid, input bit held);
        rd = rd_v;
        if (busy) sel_n = 1'b0;
        if (!held) begin
            irq = 1'b1; step(); irq = 1'b0;
        end
        if (busy) begin
            repeat (4) step();
            chk(req_n == 1'b1, "R3 no request while select held", req_n, 1);
            sel_n = 1'b1;
            step();
            step();
            chk(req_n == 1'b0, "R3 request after select freed", req_n, 0);
        end
        for (int i = 0; i < 20 && req_n; i++) step();
        chk(req_n == 1'b0, "R2 request asserted", req_n, 0);
        done_n = 1'b0; quit_n = 1'b0; step(); done_n = 1'b1; quit_n = 1'b1;
        chk(req_n == 1'b0 && ack_n == 1'b1, "R10 stray done/quit ignored", {req_n, ack_n}, 2'b01);
        prec = 1'b1; step(); step();
        chk(ack_n == 1'b1, "R4 precedence with select high ignored", ack_n, 1);
        sel_n = 1'b0; step();
        chk(ack_n == 1'b0 && req_n == 1'b1, "R4 acknowledge on grant", {ack_n, req_n}, 2'b01);
        chk(aoe && doe && addr == PANEL, "R5 address and zero data enabled", {aoe, doe, addr}, {2'b11, PANEL});
        chk(wr == !rd_v, "R7 write direction", wr, !rd_v);
        step();
        chk(strb_n == 1'b1, "R5 no strobe while precedence high", strb_n, 1);
        prec = 1'b0; step();
        chk(strb_n == 1'b0 && ack_n == 1'b0 && aoe, "R6 strobe after precedence low", {strb_n, ack_n, aoe}, 3'b001);
        if (irq_mid) begin
            irq = 1'b1; step(); irq = 1'b0;
        end
        if (use_quit) begin
            for (int i = 0; i < QUIT_CYC; i++) step();
            chk(strb_n == 1'b0, "R9 strobe held until quit", strb_n, 0);
            quit_n = 1'b0; step(); quit_n = 1'b1;
            chk_released("R9 release on quit");
        end else begin
            repeat (dly) step();
            done_n = 1'b0; step(); done_n = 1'b1;
            chk_released("R8 release on done");
        end
        sel_n = 1'b1;
    endtask

    initial begin
        repeat (3) step();
        chk_released("R1 outputs during reset");
        rst = 1'b0;
        step();
        chk_released("R1 outputs after reset");

        xfer(0, 2, 0, 0, 0, 0);
        repeat (3) step();
        xfer(1, 0, 0, 1, 0, 0);
        repeat (3) step();
        xfer(0, 0, 1, 0, 0, 0);
        repeat (3) step();
        xfer(0, 1, 0, 1, 1, 0);
        for (int i = 0; i < 10 && req_n; i++) step();
        chk(req_n == 1'b0, "R11 held request served", req_n, 0);
        xfer(0, 3, 0, 0, 0, 1);
        repeat (3) step();

        irq = 1'b1; step(); irq = 1'b0;
        for (int i = 0; i < 10 && req_n; i++) step();
        sel_n = 1'b0; prec = 1'b1; step();
        irq = 1'b1; step(); irq = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        prec = 1'b0; sel_n = 1'b1;
        chk_released("R12 reset mid-transfer");
        repeat (8) step();
        chk(req_n == 1'b1, "R12 held request discarded", req_n, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule